// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

This block is one timer channel built around a single up/down counter, 16 bits wide by default. A three-bit count-mode setting chooses what makes the counter move. It can stay idle. It can count active edges of a primary input, or both edges of it. It can count primary edges only while a secondary input is high. It can decode the two inputs as a quadrature pair. It can count primary edges with the secondary input giving the direction. It can wait for a trigger edge on the secondary input and then count until a compare match. Finally, it can follow count events from a neighbouring channel in cascade. An edge-inversion setting picks whether rising or falling edges are the active ones. Both inputs arrive already synchronised to the system clock.

The counter is checked against a compare value whenever it is about to step. If it equals the compare value at a step, it reloads to zero instead of stepping. At the same time it raises a one-cycle compare pulse and a sticky compare flag, which a one-cycle clear strobe removes. The mode and edge-inversion settings are held in a small control register written through a write strobe.

Top module: `mtc_channel`

## Requirements
- R1: After synchronous reset the count is 0, the compare pulse and the compare flag are 0, and the control register holds mode 0 with edge inversion off.
- R2: Mode 0 (binary 000) disables counting; the count holds whatever the inputs do.
- R3: Mode 1 (001) adds one for each active edge of the primary input.
- R4: With edge inversion 0 the active edge is rising; with edge inversion 1 it is falling. This applies to the primary input in modes 1, 3, 5 and 6, and to the trigger edge on the secondary input in mode 6.
- R5: Mode 2 (010) adds one for every primary transition, rising or falling, whatever the inversion setting.
- R6: Mode 3 (011) adds one for an active primary edge only when the secondary input is 1 in that same cycle.
- R7: Mode 4 (100) treats {primary, secondary} as a quadrature pair. The transitions 00→01, 01→11, 11→10 and 10→00 count up, the reverse ones count down, and a change of both bits at once leaves the count unchanged.
- R8: Mode 5 (101) steps on active primary edges, counting down when the secondary input is 1 and up when it is 0.
- R9: Mode 6 (110) counts up on active primary edges only after an active secondary edge has armed it. The first compare match disarms it, and the primary edge in the arming cycle itself is not counted.
- R10: Mode 7 (111) steps once for each cycle in which the cascade event input is 1, counting down if the cascade direction input is 1.
- R11: When a step occurs while the count equals the compare value, the count loads 0 instead of stepping and the compare pulse is 1 for exactly that following cycle.
- R12: The compare flag is set by a compare match and stays set until a cycle with the clear strobe and no match; a match in the same cycle as a clear leaves it set.
- R13: Counting down from 0 wraps to the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Loads mode_sel and edge_inv into the control register |
| mode_sel | input | 3 | Count mode to load |
| edge_inv | input | 1 | Edge inversion to load (1 = falling edges active) |
| cmp_value | input | CNT_W | Compare value |
| flag_clr | input | 1 | Clears the compare flag (write-one strobe) |
| pri_in | input | 1 | Primary count source, synchronous |
| sec_in | input | 1 | Secondary input, synchronous |
| casc_evt | input | 1 | Count event from neighbouring channel |
| casc_down | input | 1 | Direction of the cascade event (1 = down) |
| count | output | CNT_W | Current counter value |
| cmp_pulse | output | 1 | One-cycle compare-match pulse |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The hardest state to reach is in the triggered mode. There the arming edge, a primary edge, a compare match and a flag clear can fall in the same or adjacent cycles, and a second trigger can arrive after the channel has disarmed. The bench sweeps every mode under both edge polarities and with small compare values. It drives long pseudo-random sequences on both inputs and on the cascade and clear strobes, so these coincidences occur many times, including double quadrature transitions. An arithmetic model in the bench tracks the expected count, pulse and flag cycle by cycle. A directed case covers the wrap below zero.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_RISE   = 3'd1,
        MODE_BOTH   = 3'd2,
        MODE_GATED  = 3'd3,
        MODE_QUAD   = 3'd4,
        MODE_DIRSEC = 3'd5,
        MODE_TRIG   = 3'd6,
        MODE_CASC   = 3'd7
    } cnt_mode_e;

    typedef struct packed {
        cnt_mode_e mode;
        logic      inv_edge;
    } ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
        logic prev;
    } edge_t;

    typedef struct packed {
        logic step;
        logic down;
    } step_t;

    // Position of a two-bit Gray code in the forward sequence 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    // Quadrature decode: returns {step, down}
    function automatic step_t quad_decode(input logic [1:0] old_g, input logic [1:0] new_g);
        step_t     r;
        logic [1:0] d;
        d      = gray_pos(new_g) - gray_pos(old_g);
        r.step = (d == 2'd1) || (d == 2'd3);
        r.down = (d == 2'd3);
        return r;
    endfunction

endpackage

// File: rtl/mtc_edge_det.sv
module mtc_edge_det
    import mtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sig_in,
    output edge_t ev
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_in;
    end

    always_comb begin
        ev.rise  = sig_in & ~prev_q;
        ev.fall  = ~sig_in & prev_q;
        ev.level = sig_in;
        ev.prev  = prev_q;
    end
endmodule

// File: rtl/mtc_mode_dec.sv
module mtc_mode_dec
    import mtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  edge_t pri,
    input  edge_t sec,
    input  logic  casc_evt,
    input  logic  casc_down,
    input  logic  at_cmp,
    output step_t req
);
    logic act_pri;
    logic act_sec;
    logic armed_q;

    assign act_pri = ctrl.inv_edge ? pri.fall : pri.rise;
    assign act_sec = ctrl.inv_edge ? sec.fall : sec.rise;

    always_comb begin
        req = '0;
        unique case (ctrl.mode)
            MODE_OFF:    req = '0;
            MODE_RISE:   req.step = act_pri;
            MODE_BOTH:   req.step = pri.rise | pri.fall;
            MODE_GATED:  req.step = act_pri & sec.level;
            MODE_QUAD:   req = quad_decode({pri.prev, sec.prev}, {pri.level, sec.level});
            MODE_DIRSEC: begin
                req.step = act_pri;
                req.down = sec.level;
            end
            MODE_TRIG:   req.step = armed_q & act_pri;
            MODE_CASC: begin
                req.step = casc_evt;
                req.down = casc_down;
            end
            default:     req = '0;
        endcase
    end

    // Trigger-until-compare arming; a match wins over a new trigger
    always_ff @(posedge clk) begin
        if (rst)                          armed_q <= 1'b0;
        else if (ctrl.mode != MODE_TRIG)  armed_q <= 1'b0;
        else if (req.step && at_cmp)      armed_q <= 1'b0;
        else if (act_sec)                 armed_q <= 1'b1;
    end
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter
    import mtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            req,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             at_cmp,
    output logic             cmp_pulse,
    output logic             cmp_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             flag_q;
    logic             hit;

    assign at_cmp = (cnt_q == cmp_value);
    assign hit    = req.step & at_cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit)           cnt_q <= '0;
            else if (req.step) cnt_q <= req.down ? cnt_q - ONE : cnt_q + ONE;
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign count     = cnt_q;
    assign cmp_pulse = pulse_q;
    assign cmp_flag  = flag_q;
endmodule

// File: rtl/mtc_channel.sv
module mtc_channel
    import mtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [2:0]       mode_sel,
    input  logic             edge_inv,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             flag_clr,
    input  logic             pri_in,
    input  logic             sec_in,
    input  logic             casc_evt,
    input  logic             casc_down,
    output logic [CNT_W-1:0] count,
    output logic             cmp_pulse,
    output logic             cmp_flag
);
    localparam int N_IN = 2;

    ctrl_t           ctrl_q;
    logic [N_IN-1:0] raw_in;
    edge_t           ev [N_IN];
    step_t           req;
    logic            at_cmp;
    logic [2:0]      mode_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.mode     <= cnt_mode_e'(mode_sel);
            ctrl_q.inv_edge <= edge_inv;
        end
    end

    assign mode_bits = ctrl_q.mode;
    assign raw_in    = {sec_in, pri_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_edge
        mtc_edge_det u_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_in (raw_in[i]),
            .ev     (ev[i])
        );
    end

    mtc_mode_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .pri       (ev[0]),
        .sec       (ev[1]),
        .casc_evt  (casc_evt),
        .casc_down (casc_down),
        .at_cmp    (at_cmp),
        .req       (req)
    );

    mtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cmp_value (cmp_value),
        .flag_clr  (flag_clr),
        .count     (count),
        .at_cmp    (at_cmp),
        .cmp_pulse (cmp_pulse),
        .cmp_flag  (cmp_flag)
    );
endmodule

// File: rtl/mtc_channel_chk.sv
module mtc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       mode,
    input logic             sec_in,
    input logic             casc_evt,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             cmp_pulse,
    input logic             cmp_flag
);
    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0) |=> $stable(count));

    assert_gate_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && !sec_in) |=> $stable(count));

    assert_casc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd7 && !casc_evt) |=> $stable(count));

    assert_reload_zero_R11: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> (count == '0));

    assert_unit_step_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == '0 ||
                  count == CNT_W'($past(count) + 1'b1) ||
                  count == CNT_W'($past(count) - 1'b1)));

    assert_flag_on_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> cmp_flag);

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag && !flag_clr) |=> cmp_flag);
endmodule

bind mtc_channel mtc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_bits),
    .sec_in    (sec_in),
    .casc_evt  (casc_evt),
    .flag_clr  (flag_clr),
    .count     (count),
    .cmp_pulse (cmp_pulse),
    .cmp_flag  (cmp_flag)
);

// File: tb/mtc_channel_tb.sv
`timescale 1ns/1ps
module mtc_channel_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_we = 1'b0;
    logic [2:0]   mode_sel = 3'd0;
    logic         edge_inv = 1'b0;
    logic [W-1:0] cmp_value = '0;
    logic         flag_clr = 1'b0;
    logic         pri_in = 1'b0;
    logic         sec_in = 1'b0;
    logic         casc_evt = 1'b0;
    logic         casc_down = 1'b0;
    logic [W-1:0] count;
    logic         cmp_pulse;
    logic         cmp_flag;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [W-1:0] m_cnt;
    logic         m_pulse, m_flag, m_arm, pp, ps;
    logic [2:0]   m_mode;
    logic         m_inv;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    mtc_channel #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .mode_sel(mode_sel),
        .edge_inv(edge_inv), .cmp_value(cmp_value), .flag_clr(flag_clr),
        .pri_in(pri_in), .sec_in(sec_in), .casc_evt(casc_evt),
        .casc_down(casc_down), .count(count), .cmp_pulse(cmp_pulse),
        .cmp_flag(cmp_flag)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (mode %0d inv %0d)", tag, act, exp, m_mode, m_inv);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] next_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // one clock cycle with model update; called at a negedge
    task automatic cyc(input logic p, input logic s, input logic ce, input logic cd, input logic clr);
        logic ap, as_, st, dn, hit;
        logic [1:0] o, n;
        pri_in = p; sec_in = s; casc_evt = ce; casc_down = cd; flag_clr = clr;
        ap  = m_inv ? (pp & ~p) : (~pp & p);
        as_ = m_inv ? (ps & ~s) : (~ps & s);
        o = {pp, ps}; n = {p, s};
        st = 1'b0; dn = 1'b0;
        case (m_mode)
            3'd1: st = ap;
            3'd2: st = (p != pp);
            3'd3: st = ap & s;
            3'd4: begin
                if ((o == 2'b00 && n == 2'b01) || (o == 2'b01 && n == 2'b11) ||
                    (o == 2'b11 && n == 2'b10) || (o == 2'b10 && n == 2'b00)) st = 1'b1;
                if ((n == 2'b00 && o == 2'b01) || (n == 2'b01 && o == 2'b11) ||
                    (n == 2'b11 && o == 2'b10) || (n == 2'b10 && o == 2'b00)) begin
                    st = 1'b1; dn = 1'b1;
                end
            end
            3'd5: begin st = ap; dn = s; end
            3'd6: st = m_arm & ap;
            3'd7: begin st = ce; dn = cd; end
            default: st = 1'b0;
        endcase
        hit = st && (m_cnt == cmp_value);
        if (m_mode != 3'd6) m_arm = 1'b0;
        else if (hit)       m_arm = 1'b0;
        else if (as_)       m_arm = 1'b1;
        m_pulse = hit;
        if (hit)      m_cnt = '0;
        else if (st)  m_cnt = dn ? m_cnt - 1'b1 : m_cnt + 1'b1;
        if (hit)      m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        pp = p; ps = s;
        @(posedge clk);
        @(negedge clk);
        check({mode_tag(m_mode), m_inv ? "/R4" : "", " count"}, count, m_cnt);
        check("R11 pulse", {15'd0, cmp_pulse}, {15'd0, m_pulse});
        check("R12 flag", {15'd0, cmp_flag}, {15'd0, m_flag});
    endtask

    task automatic restart(input logic [2:0] m, input logic inv, input logic [W-1:0] cv);
        rst = 1'b1; pri_in = 0; sec_in = 0; casc_evt = 0; casc_down = 0; flag_clr = 0;
        cmp_value = cv;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_cnt = '0; m_pulse = 0; m_flag = 0; m_arm = 0; pp = 0; ps = 0;
        m_mode = 3'd0; m_inv = 1'b0;
        ctrl_we = 1'b1; mode_sel = m; edge_inv = inv;
        @(negedge clk);
        ctrl_we = 1'b0;
        m_mode = m; m_inv = inv;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_mode = 3'd0; m_inv = 1'b0;
        // R1: reset state
        check("R1 count", count, '0);
        check("R1 pulse", {15'd0, cmp_pulse}, 16'd0);
        check("R1 flag", {15'd0, cmp_flag}, 16'd0);
        // R1/R2: reset control holds mode 0, so edges do nothing
        m_cnt = '0; m_pulse = 0; m_flag = 0; m_arm = 0; pp = 0; ps = 0;
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0);

        // Sweep every mode, polarity and a few compare values
        for (int m = 0; m < 8; m++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int c = 0; c < 3; c++) begin
                    restart(3'(m), 1'(inv), (c == 0) ? 16'd0 : (c == 1) ? 16'd3 : 16'd6);
                    for (int k = 0; k < 160; k++) begin
                        lfsr = next_lfsr(lfsr);
                        cyc(lfsr[3] ? ~pp : pp,
                            (lfsr[6] & lfsr[1]) ? ~ps : ps,
                            lfsr[8], lfsr[11] & lfsr[9],
                            (k % 23) == 22);
                    end
                end
            end
        end

        // R13: down from zero wraps to all ones (mode 5, secondary high)
        restart(3'd5, 1'b0, 16'd5);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        check("R13 wrap", count, 16'hFFFF);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        check("R13 wrap next", count, 16'hFFFE);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule